// File: doc/BRIEF.md
# Layered Program ROM Bank Mapper

This block sits between a CPU and a 32 MiB program ROM. It turns a CPU address in the upper half of the 16-bit space ($8000-$FFFF) into a 25-bit ROM byte address. The upper half is divided into four 8 KiB slots. Each slot gets a 12-bit bank number, and that bank number is joined with the low 13 CPU address bits to form the ROM address.

The bank number is assembled in layers. An inner bank value is AND-masked. A middle register fills in the bits that the mask removes. A 4-bit outer bank sits at bits 11:8. An 11-bit relative offset is then added to the result. A small register file in the $41xx page holds every bank and control field. It is written through a single-cycle write strobe and can be read back through a separate read port. The mapping path is purely combinational from the CPU address and the register contents.

Top module: `prg_bank_mapper`

## Requirements
- R1: `rom_select` equals CPU A15. When it is high, `rom_addr[12:0]` equals `cpu_addr[12:0]` and `rom_addr[24:13]` is the slot's 12-bit bank number. The slot index is {A14 xor swap, A13}: slot 0 covers $8000, slot 1 $A000, slot 2 $C000 and slot 3 $E000.
- R2: The inner bank of slot 0 comes from the register at $4107. The inner bank of slot 1 comes from the register at $4108.
- R3: The inner bank of slot 2 is fixed at $FE when bit 6 of $410B is 0, and comes from $4109 when that bit is 1. The inner bank of slot 3 is always $FF.
- R4: When bit 6 of $4105 is 1, the slot index uses inverted A14. As a result, every source (inner, outer and fixed values) for $8000-$BFFF is exchanged with the source for $C000-$FFFF.
- R5: Bits 2:0 of $410B select the inner mask: 0→$3F, 1→$1F, 2→$0F, 3→$07, 4→$03, 5→$01, 6→$00, 7→$FF.
- R6: Each bit position that the inner mask clears is taken from the register at $410A. The low 8 bank bits are therefore (inner AND mask) OR (middle AND NOT mask).
- R7: When bit 5 of $411C is 0, all slots place bits 7:4 of $4100 at bank bits 11:8.
- R8: When bit 5 of $411C is 1, the outer bank is assigned per slot. Slot 0 uses $4110[3:0] and slot 1 uses $4110[7:4]. Slot 2 uses $4111[3:0] if bit 6 of $410B is set, and $4100[7:4] otherwise. Slot 3 uses $4100[7:4].
- R9: The 11-bit value {$4128[2:0], $4127[7:0]} is added to the combined bank number, and the sum is truncated to 12 bits.
- R10: After a synchronous active-low reset, every register reads 0. The mapping then gives mask $3F, outer 0, no swap and offset 0, so $E000 maps to bank $03F.
- R11: A write takes effect on the clock edge where the strobe is sampled. Each implemented register reads back its full written byte. A write to any unused address changes no register and no mapping, and unused addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_addr | input | 16 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 16 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| cpu_addr | input | 16 | CPU address to translate |
| rom_addr | output | 25 | ROM byte address |
| rom_select | output | 1 | High when CPU A15 is 1 |

## Verification
The main mapping is swept across all eight mask selections, both swap states, both slot-2 select states and both outer modes, with every slot visited at several offsets.

The inner, middle and outer registers hold distinct, non-overlapping bit patterns. Because of this, any wrong source choice, any wrong mask bit or any failure to swap shows up as a distinct wrong bank.

A second register set with nonzero relative offsets separates the additive layer from OR-combination. An all-ones base with the maximum offset checks the truncation at 12 bits.

Writes to unused addresses are followed by readback and by remapping, to show that they have no effect.

// File: rtl/prg_map_pkg.sv
// Package: shared widths, register addresses and the mask table for the
// program bank mapper. Assumes byte-wide registers in a 16-bit address page.
package prg_map_pkg;

    localparam int CPU_AW    = 16;
    localparam int DATA_W    = 8;
    localparam int INNER_W   = 8;
    localparam int OUTER_W   = 4;
    localparam int REL_W     = 11;
    localparam int BANK_W    = INNER_W + OUTER_W;
    localparam int OFFSET_W  = 13;
    localparam int ROM_AW    = BANK_W + OFFSET_W;
    localparam int NUM_SLOTS = 4;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    // Register addresses (software-visible layout)
    localparam logic [CPU_AW-1:0] RA_OUTER_GLB = 16'h4100;
    localparam logic [CPU_AW-1:0] RA_MODE      = 16'h4105;
    localparam logic [CPU_AW-1:0] RA_INNER0    = 16'h4107;
    localparam logic [CPU_AW-1:0] RA_INNER1    = 16'h4108;
    localparam logic [CPU_AW-1:0] RA_INNER2    = 16'h4109;
    localparam logic [CPU_AW-1:0] RA_MIDDLE    = 16'h410A;
    localparam logic [CPU_AW-1:0] RA_SIZE      = 16'h410B;
    localparam logic [CPU_AW-1:0] RA_OUTER01   = 16'h4110;
    localparam logic [CPU_AW-1:0] RA_OUTER2    = 16'h4111;
    localparam logic [CPU_AW-1:0] RA_EXT       = 16'h411C;
    localparam logic [CPU_AW-1:0] RA_REL_LO    = 16'h4127;
    localparam logic [CPU_AW-1:0] RA_REL_HI    = 16'h4128;

    // Control bit positions
    localparam int SWAP_BIT    = 6;
    localparam int SLOT2_EN    = 6;
    localparam int PERSLOT_BIT = 5;

    typedef struct packed {
        logic [DATA_W-1:0] outer_glb;
        logic [DATA_W-1:0] mode;
        logic [DATA_W-1:0] inner0;
        logic [DATA_W-1:0] inner1;
        logic [DATA_W-1:0] inner2;
        logic [DATA_W-1:0] middle;
        logic [DATA_W-1:0] size;
        logic [DATA_W-1:0] outer01;
        logic [DATA_W-1:0] outer2;
        logic [DATA_W-1:0] ext;
        logic [DATA_W-1:0] rel_lo;
        logic [DATA_W-1:0] rel_hi;
    } prg_regs_t;

    // Inner AND mask from the 3-bit size selector
    function automatic logic [INNER_W-1:0] inner_mask(input logic [2:0] sel);
        logic [INNER_W-1:0] m;
        if (sel == 3'd7) m = '1;
        else             m = 8'h3F >> sel;
        return m;
    endfunction

endpackage

// File: rtl/prg_bank_regs.sv
// Register file for the bank mapper. Decodes a single-cycle write strobe
// against the full 16-bit address; unused addresses are ignored. Read port
// is combinational and returns 0 for unused addresses.
module prg_bank_regs
    import prg_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CPU_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CPU_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output prg_regs_t         regs
);

    prg_regs_t regs_q;

    // Register update: clear on reset, load the addressed byte on a strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                RA_OUTER_GLB: regs_q.outer_glb <= wr_data;
                RA_MODE:      regs_q.mode      <= wr_data;
                RA_INNER0:    regs_q.inner0    <= wr_data;
                RA_INNER1:    regs_q.inner1    <= wr_data;
                RA_INNER2:    regs_q.inner2    <= wr_data;
                RA_MIDDLE:    regs_q.middle    <= wr_data;
                RA_SIZE:      regs_q.size      <= wr_data;
                RA_OUTER01:   regs_q.outer01   <= wr_data;
                RA_OUTER2:    regs_q.outer2    <= wr_data;
                RA_EXT:       regs_q.ext       <= wr_data;
                RA_REL_LO:    regs_q.rel_lo    <= wr_data;
                RA_REL_HI:    regs_q.rel_hi    <= wr_data;
                default:      ;
            endcase
        end
    end

    // Readback multiplexer
    always_comb begin
        case (rd_addr)
            RA_OUTER_GLB: rd_data = regs_q.outer_glb;
            RA_MODE:      rd_data = regs_q.mode;
            RA_INNER0:    rd_data = regs_q.inner0;
            RA_INNER1:    rd_data = regs_q.inner1;
            RA_INNER2:    rd_data = regs_q.inner2;
            RA_MIDDLE:    rd_data = regs_q.middle;
            RA_SIZE:      rd_data = regs_q.size;
            RA_OUTER01:   rd_data = regs_q.outer01;
            RA_OUTER2:    rd_data = regs_q.outer2;
            RA_EXT:       rd_data = regs_q.ext;
            RA_REL_LO:    rd_data = regs_q.rel_lo;
            RA_REL_HI:    rd_data = regs_q.rel_hi;
            default:      rd_data = '0;
        endcase
    end

    assign regs = regs_q;

    // R11: a strobed write to slot-0 inner register lands on the next edge
    a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_addr) == RA_INNER0)
            |-> regs_q.inner0 == $past(wr_data));

    // R11: without a strobe no register changes
    a_r11_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en)) |-> $stable(regs_q));

    // R10: the cycle after reset every register is zero
    a_r10_reset_clear: assert property (@(posedge clk)
        !$past(rst_n) |-> regs_q == '0);

endmodule

// File: rtl/prg_slot_mux.sv
// Per-slot source selection. Builds the inner and outer values for each of
// the four slots from the registers, then picks the slot addressed by the
// CPU (A14 inverted when the swap bit is set). Assumes NUM_SLOTS == 4.
module prg_slot_mux
    import prg_map_pkg::*;
(
    input  prg_regs_t          regs,
    input  logic [CPU_AW-1:0]  cpu_addr,
    output logic [INNER_W-1:0] inner_sel,
    output logic [OUTER_W-1:0] outer_sel
);

    localparam logic [INNER_W-1:0] FIXED_C = 8'hFE;
    localparam logic [INNER_W-1:0] FIXED_E = 8'hFF;

    logic [INNER_W-1:0] inner_v [NUM_SLOTS];
    logic [OUTER_W-1:0] outer_v [NUM_SLOTS];
    logic [SLOT_W-1:0]  slot;
    logic               swap;
    logic               slot2_en;
    logic               per_slot;
    logic [OUTER_W-1:0] outer_glb;

    assign swap      = regs.mode[SWAP_BIT];
    assign slot2_en  = regs.size[SLOT2_EN];
    assign per_slot  = regs.ext[PERSLOT_BIT];
    assign outer_glb = regs.outer_glb[DATA_W-1 -: OUTER_W];

    // Slot index from the CPU address; swap flips A14
    assign slot = {cpu_addr[14] ^ swap, cpu_addr[13]};

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        if (s == 0) begin : g_s0
            // Slot 0 sources
            always_comb begin
                inner_v[s] = regs.inner0;
                outer_v[s] = per_slot ? regs.outer01[OUTER_W-1:0] : outer_glb;
            end
        end else if (s == 1) begin : g_s1
            // Slot 1 sources
            always_comb begin
                inner_v[s] = regs.inner1;
                outer_v[s] = per_slot ? regs.outer01[DATA_W-1 -: OUTER_W] : outer_glb;
            end
        end else if (s == 2) begin : g_s2
            // Slot 2 sources: fixed or selectable
            always_comb begin
                inner_v[s] = slot2_en ? regs.inner2 : FIXED_C;
                outer_v[s] = (per_slot && slot2_en) ? regs.outer2[OUTER_W-1:0] : outer_glb;
            end
        end else begin : g_s3
            // Slot 3 sources: always fixed last bank
            always_comb begin
                inner_v[s] = FIXED_E;
                outer_v[s] = outer_glb;
            end
        end
    end

    // Select the addressed slot
    always_comb begin
        inner_sel = inner_v[slot];
        outer_sel = outer_v[slot];
    end

endmodule

// File: rtl/prg_bank_compose.sv
// Bank number arithmetic: masks the inner value, fills cleared bits from
// the middle register, places the outer bank on top, then adds the
// relative offset with truncation to BANK_W bits. Purely combinational.
module prg_bank_compose
    import prg_map_pkg::*;
(
    input  logic [INNER_W-1:0] inner,
    input  logic [INNER_W-1:0] middle,
    input  logic [2:0]         mask_sel,
    input  logic [OUTER_W-1:0] outer,
    input  logic [REL_W-1:0]   rel,
    output logic [BANK_W-1:0]  bank
);

    logic [INNER_W-1:0] mask;
    logic [INNER_W-1:0] low;
    logic [BANK_W-1:0]  base;

    // Mask/fill/stack/add chain
    always_comb begin
        mask = inner_mask(mask_sel);
        low  = (inner & mask) | (middle & ~mask);
        base = {outer, low};
        bank = base + BANK_W'(rel);
    end

    // R5: the mask table never yields a value outside the legal set
    always_comb begin
        a_r5_mask_legal: assert (mask == 8'hFF || mask == 8'h3F || mask == 8'h1F
            || mask == 8'h0F || mask == 8'h07 || mask == 8'h03 || mask == 8'h01
            || mask == 8'h00);
    end

endmodule

// File: rtl/prg_bank_mapper.sv
// Top of the program bank mapper: register file, slot source selection and
// bank arithmetic. Output address is combinational; rom_addr is meaningful
// only while rom_select is high.
module prg_bank_mapper
    import prg_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [15:0]       wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [15:0]       rd_addr,
    output logic [7:0]        rd_data,
    input  logic [15:0]       cpu_addr,
    output logic [24:0]       rom_addr,
    output logic              rom_select
);

    prg_regs_t          regs;
    logic [INNER_W-1:0] inner_sel;
    logic [OUTER_W-1:0] outer_sel;
    logic [BANK_W-1:0]  bank;
    logic [REL_W-1:0]   rel;

    prg_bank_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .regs    (regs)
    );

    prg_slot_mux u_mux (
        .regs      (regs),
        .cpu_addr  (cpu_addr),
        .inner_sel (inner_sel),
        .outer_sel (outer_sel)
    );

    assign rel = {regs.rel_hi[REL_W-DATA_W-1:0], regs.rel_lo};

    prg_bank_compose u_comp (
        .inner    (inner_sel),
        .middle   (regs.middle),
        .mask_sel (regs.size[2:0]),
        .outer    (outer_sel),
        .rel      (rel),
        .bank     (bank)
    );

    // Output address formation
    assign rom_addr   = {bank, cpu_addr[OFFSET_W-1:0]};
    assign rom_select = cpu_addr[CPU_AW-1];

    // R3: slot 3 with the default mask and no offset lands on inner $3F
    a_r3_last_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_select && (cpu_addr[14] ^ regs.mode[SWAP_BIT]) && cpu_addr[13]
         && regs.size[2:0] == 3'd0 && rel == '0) |-> rom_addr[18:13] == 6'h3F);

    // R7: with shared outer mode and zero offset, top bits follow $4100[7:4]
    a_r7_outer_global: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_select && !regs.ext[PERSLOT_BIT] && rel == '0)
            |-> rom_addr[24:21] == regs.outer_glb[7:4]);

    // R5: mask 7 passes the slot-0 inner register straight through
    a_r5_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_select && !(cpu_addr[14] ^ regs.mode[SWAP_BIT]) && !cpu_addr[13]
         && regs.size[2:0] == 3'd7 && rel == '0) |-> rom_addr[20:13] == regs.inner0);

    // R1: in-bank offset is the low CPU address bits
    a_r1_offset_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        rom_select |-> rom_addr[12:0] == cpu_addr[12:0]);

endmodule

// File: tb/tb_prg_bank_mapper.sv
module tb_prg_bank_mapper;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [15:0] wr_addr = 0;
    logic [7:0]  wr_data = 0;
    logic [15:0] rd_addr = 0;
    logic [7:0]  rd_data;
    logic [15:0] cpu_addr = 0;
    logic [24:0] rom_addr;
    logic        rom_select;

    int n_chk = 0;
    int n_bad = 0;

    // bench shadow of written values
    logic [7:0] s_og, s_mode, s_i0, s_i1, s_i2, s_mid, s_size, s_o01, s_o2, s_ext, s_rlo, s_rhi;

    always #4 clk = ~clk;

    prg_bank_mapper dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cpu_addr(cpu_addr), .rom_addr(rom_addr), .rom_select(rom_select)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        case (a)
            16'h4100: s_og = d;   16'h4105: s_mode = d; 16'h4107: s_i0 = d;
            16'h4108: s_i1 = d;   16'h4109: s_i2 = d;   16'h410A: s_mid = d;
            16'h410B: s_size = d; 16'h4110: s_o01 = d;  16'h4111: s_o2 = d;
            16'h411C: s_ext = d;  16'h4127: s_rlo = d;  16'h4128: s_rhi = d;
            default: ;
        endcase
    endtask

    function automatic logic [11:0] exp_bank(input logic [15:0] a);
        logic [1:0]  slot;
        logic [7:0]  inr, m;
        logic [3:0]  outr;
        logic        en, per;
        logic [11:0] base;
        slot = {a[14] ^ s_mode[6], a[13]};
        en  = s_size[6];
        per = s_ext[5];
        case (s_size[2:0])
            3'd0: m = 8'h3F; 3'd1: m = 8'h1F; 3'd2: m = 8'h0F; 3'd3: m = 8'h07;
            3'd4: m = 8'h03; 3'd5: m = 8'h01; 3'd6: m = 8'h00; default: m = 8'hFF;
        endcase
        case (slot)
            2'd0: begin inr = s_i0; outr = per ? s_o01[3:0] : s_og[7:4]; end
            2'd1: begin inr = s_i1; outr = per ? s_o01[7:4] : s_og[7:4]; end
            2'd2: begin inr = en ? s_i2 : 8'hFE; outr = (per && en) ? s_o2[3:0] : s_og[7:4]; end
            default: begin inr = 8'hFF; outr = s_og[7:4]; end
        endcase
        base = {outr, (inr & m) | (s_mid & ~m)};
        return base + {1'b0, s_rhi[2:0], s_rlo};
    endfunction

    // sweep every mode combination for the current register values
    task automatic sweep(input string tag);
        for (int ms = 0; ms < 8; ms++)
        for (int sw = 0; sw < 2; sw++)
        for (int en = 0; en < 2; en++)
        for (int ps = 0; ps < 2; ps++) begin
            wr(16'h410B, {1'b0, 1'(en), 3'b0, 3'(ms)});
            wr(16'h4105, {1'b0, 1'(sw), 6'h15});
            wr(16'h411C, {2'b0, 1'(ps), 5'h0A});
            for (int sl = 0; sl < 4; sl++)
            for (int off = 0; off < 2; off++) begin
                logic [15:0] a;
                a = {1'b1, 2'(sl), (off == 0) ? 13'h0000 : 13'h1A5C};
                @(negedge clk);
                cpu_addr = a;
                #1;
                check({tag, " R1/R2/R3/R4/R5/R6/R7/R8"}, {7'b0, rom_addr},
                      {7'b0, exp_bank(a), a[12:0]});
            end
        end
    endtask

    initial begin
        s_og = 0; s_mode = 0; s_i0 = 0; s_i1 = 0; s_i2 = 0; s_mid = 0;
        s_size = 0; s_o01 = 0; s_o2 = 0; s_ext = 0; s_rlo = 0; s_rhi = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R10: reset state
        rd_addr = 16'h4107; #1; check("R10 readback inner0", {24'b0, rd_data}, 0);
        rd_addr = 16'h4100; #1; check("R10 readback outer", {24'b0, rd_data}, 0);
        cpu_addr = 16'hE000; #1; check("R10 E000 bank", {7'b0, rom_addr}, {7'b0, 12'h03F, 13'h0});
        cpu_addr = 16'h8123; #1; check("R10 8000 bank", {7'b0, rom_addr}, {7'b0, 12'h000, 13'h0123});

        // R1: rom_select follows A15
        cpu_addr = 16'h7FFF; #1; check("R1 select low", {31'b0, rom_select}, 0);
        cpu_addr = 16'h8000; #1; check("R1 select high", {31'b0, rom_select}, 1);

        // distinct patterns per source
        wr(16'h4100, 8'hA0); wr(16'h4107, 8'h5A); wr(16'h4108, 8'hC3);
        wr(16'h4109, 8'h96); wr(16'h410A, 8'h6C); wr(16'h4110, 8'h73);
        wr(16'h4111, 8'h0D);

        // R11: readback of written bytes
        rd_addr = 16'h4110; #1; check("R11 readback outer01", {24'b0, rd_data}, 32'h73);
        rd_addr = 16'h410A; #1; check("R11 readback middle", {24'b0, rd_data}, 32'h6C);

        sweep("set A");

        // R9: relative offset layer
        wr(16'h4127, 8'h35); wr(16'h4128, 8'hFD);
        sweep("set B R9");

        // R9: truncation at 12 bits
        wr(16'h4100, 8'hF0); wr(16'h410B, 8'h07); wr(16'h4105, 8'h00);
        wr(16'h411C, 8'h00); wr(16'h4127, 8'hFF); wr(16'h4128, 8'h07);
        @(negedge clk); cpu_addr = 16'hE001; #1;
        check("R9 wrap", {7'b0, rom_addr}, {7'b0, 12'h7FE, 13'h0001});

        // R11: unused address writes ignored
        wr(16'h4101, 8'hFF); wr(16'h4106, 8'hFF); wr(16'h4129, 8'hFF); wr(16'h5107, 8'hFF);
        rd_addr = 16'h4101; #1; check("R11 unused reads 0", {24'b0, rd_data}, 0);
        rd_addr = 16'h4107; #1; check("R11 inner0 untouched", {24'b0, rd_data}, 32'h5A);
        cpu_addr = 16'hE001; #1;
        check("R11 mapping untouched", {7'b0, rom_addr}, {7'b0, 12'h7FE, 13'h0001});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule